// File: doc/BRIEF.md
# Multicycle Instruction Phase Sequencer

This block is the control state machine of a small, non-pipelined 32-bit integer core that has a single memory port for both instructions and data. Each instruction goes through three phases in turn: fetch, decode, and one or more execute cycles. Instructions never overlap.

During fetch, the program counter addresses memory and the counter moves ahead by one instruction word. Memory answers one cycle later, so the instruction word is present during decode. At the end of decode the word is captured, together with:

- the register indices,
- the function code,
- the sign-extended immediate,
- a shift classification.

During execute, the port is switched over to the data address. A taken branch overwrites the program counter. The register-file write strobe fires once, in the last execute cycle.

Two sources can lengthen execute: an iterative shifter, which stalls one cycle per bit shifted, and an unaligned-access unit, which stalls one cycle for the second word. While either stall is raised, the sequencer holds the program counter and all captured fields. It moves back to fetch on the first cycle in which no stall is raised.

Top module: `phase_seq`

## Requirements
- R1: While `rst_ni` is low, the phase is fetch (`phase_o` = 0), `pc_o` equals the reset address 0, `rf_we_o` is low and `mem_data_sel_o` is low.
- R2: Phases run fetch (0), decode (1), execute (2), then back to fetch. `mem_data_sel_o` is 0 (instruction address) in fetch and decode, and 1 (data address) in every execute cycle.
- R3: At the end of the fetch cycle `pc_o` increases by 4, so during decode it reads the fetched address plus 4.
- R4: The word on `mem_rdata_i` during decode is captured at the end of that cycle. `rd_o` = bits 11:7, `rs1_o` = bits 19:15, `rs2_o` = bits 24:20, `funct3_o` = bits 14:12. Words present in other phases are not captured.
- R5: `imm_o` is the sign-extended immediate, selected by opcode bits 6:0:
  - I format for 0000011, 0010011 and 1100111;
  - S format for 0100011;
  - B format (bit 0 forced to 0) for 1100011;
  - U format (low 12 bits 0) for 0110111 and 0010111;
  - J format for 1101111;
  - zero for any other opcode.
- R6: `shift_op_o` is 1 when the opcode is 0010011 or 0110011 and funct3 is 001 or 101. For a shift, `shift_right_o` equals funct3 bit 2 and `shift_arith_o` equals instruction bit 30 for right shifts. All three flags are 0 for non-shifts, and `shift_arith_o` is 0 for left shifts.
- R7: An execute cycle in which `shift_stall_i` or `unalign_stall_i` is high is followed by another execute cycle, with `pc_o` and the captured fields unchanged. With no stall, an instruction takes exactly 3 cycles.
- R8: A shift stall lasting N cycles gives an instruction length of 3 + N cycles. A one-cycle unaligned stall gives 4 cycles.
- R9: `branch_taken_i` is used only in the final, unstalled execute cycle. In that cycle a high value loads `branch_target_i` into `pc_o` for the next fetch. In any other cycle it has no effect.
- R10: `rf_we_o` is high in at most one cycle per instruction, the final execute cycle. It stays low when rd is 0, and for store (0100011) and branch (1100011) opcodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_rdata_i | input | 32 | Read data from the shared memory port |
| shift_stall_i | input | 1 | Stall request from the iterative shifter |
| unalign_stall_i | input | 1 | Stall request from the unaligned-access unit |
| branch_taken_i | input | 1 | Branch/jump condition from the ALU |
| branch_target_i | input | PC_W | Branch/jump destination address |
| phase_o | output | 2 | Current phase: 0 fetch, 1 decode, 2 execute |
| pc_o | output | PC_W | Program counter |
| mem_data_sel_o | output | 1 | Port address select: 0 PC, 1 data address |
| ir_en_o | output | 1 | Instruction/immediate capture strobe (decode) |
| rf_we_o | output | 1 | Register-file write enable |
| instr_o | output | 32 | Captured instruction word |
| rd_o | output | 5 | Destination register index |
| rs1_o | output | 5 | First source register index |
| rs2_o | output | 5 | Second source register index |
| funct3_o | output | 3 | Function code |
| imm_o | output | 32 | Sign-extended immediate |
| shift_op_o | output | 1 | Instruction is a shift |
| shift_right_o | output | 1 | Shift direction is right |
| shift_arith_o | output | 1 | Right shift is arithmetic |

## Verification
The assertions assume that the stall units and the ALU obey the sequencer's phases:

- stall requests are raised only during execute;
- no stall is held forever;
- the branch inputs are read only at the final execute edge.

The bench stubs respect these assumptions. They drive both stall lines from a per-instruction plan, starting at the first execute cycle and dropping before the last one. They keep the stalls low in fetch and decode.

Outside the final cycle, the stubs deliberately drive a taken branch with a junk target, and a zero memory word outside decode. The assertions and the scoreboard therefore see these values only in cycles where the block must ignore them.

// File: rtl/phase_seq_pkg.sv
package phase_seq_pkg;
  typedef enum logic [1:0] {
    PH_FETCH  = 2'd0,
    PH_DECODE = 2'd1,
    PH_EXEC   = 2'd2
  } phase_e;

  localparam int unsigned ILEN   = 32;
  localparam int unsigned REG_AW = 5;

  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;

  typedef struct packed {
    logic [REG_AW-1:0] rd;
    logic [REG_AW-1:0] rs1;
    logic [REG_AW-1:0] rs2;
    logic [2:0]        funct3;
  } fields_t;
endpackage

// File: rtl/seq_fsm.sv
module seq_fsm
  import phase_seq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   stall_i,
  output phase_e phase_o,
  output logic   fetch_o,
  output logic   decode_o,
  output logic   exec_o,
  output logic   exec_last_o
);
  phase_e state_q, state_d;

  always_comb begin
    unique case (state_q)
      PH_FETCH:  state_d = PH_DECODE;
      PH_DECODE: state_d = PH_EXEC;
      PH_EXEC:   state_d = stall_i ? PH_EXEC : PH_FETCH;
      default:   state_d = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PH_FETCH;
    else         state_q <= state_d;
  end

  assign phase_o     = state_q;
  assign fetch_o     = (state_q == PH_FETCH);
  assign decode_o    = (state_q == PH_DECODE);
  assign exec_o      = (state_q == PH_EXEC);
  assign exec_last_o = exec_o && !stall_i;
endmodule

// File: rtl/seq_pc.sv
module seq_pc #(
  parameter int unsigned     PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            step_i,
  input  logic            load_i,
  input  logic [PC_W-1:0] target_i,
  output logic [PC_W-1:0] pc_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(phase_seq_pkg::ILEN / 8);

  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= RESET_PC;
    else if (load_i) pc_q <= target_i;
    else if (step_i) pc_q <= pc_q + STEP;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/seq_decode.sv
module seq_decode
  import phase_seq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [ILEN-1:0] word_i,
  output logic [ILEN-1:0] instr_o,
  output fields_t         fields_o,
  output logic [ILEN-1:0] imm_o,
  output logic            shift_op_o,
  output logic            shift_right_o,
  output logic            shift_arith_o,
  output logic            wb_ok_o
);
  logic [6:0]      opc;
  logic [2:0]      f3;
  logic [ILEN-1:0] imm_d;
  logic            is_shift, wb_ok_d;
  fields_t         fields_d;

  assign opc = word_i[6:0];
  assign f3  = word_i[14:12];

  always_comb begin
    unique case (opc)
      OPC_LOAD, OPC_OPIMM, OPC_JALR:
        imm_d = {{20{word_i[31]}}, word_i[31:20]};
      OPC_STORE:
        imm_d = {{20{word_i[31]}}, word_i[31:25], word_i[11:7]};
      OPC_BRANCH:
        imm_d = {{19{word_i[31]}}, word_i[31], word_i[7], word_i[30:25],
                 word_i[11:8], 1'b0};
      OPC_LUI, OPC_AUIPC:
        imm_d = {word_i[31:12], 12'b0};
      OPC_JAL:
        imm_d = {{11{word_i[31]}}, word_i[31], word_i[19:12], word_i[20],
                 word_i[30:21], 1'b0};
      default:
        imm_d = '0;
    endcase
  end

  assign is_shift = ((opc == OPC_OPIMM) || (opc == OPC_OP)) &&
                    ((f3 == 3'b001) || (f3 == 3'b101));

  // no write-back for stores, branches or x0
  assign wb_ok_d = (opc != OPC_STORE) && (opc != OPC_BRANCH) &&
                   (word_i[11:7] != '0);

  assign fields_d = '{rd: word_i[11:7], rs1: word_i[19:15],
                      rs2: word_i[24:20], funct3: f3};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      instr_o       <= '0;
      fields_o      <= '0;
      imm_o         <= '0;
      shift_op_o    <= 1'b0;
      shift_right_o <= 1'b0;
      shift_arith_o <= 1'b0;
      wb_ok_o       <= 1'b0;
    end else if (en_i) begin
      instr_o       <= word_i;
      fields_o      <= fields_d;
      imm_o         <= imm_d;
      shift_op_o    <= is_shift;
      shift_right_o <= is_shift && f3[2];
      shift_arith_o <= is_shift && f3[2] && word_i[30];
      wb_ok_o       <= wb_ok_d;
    end
  end
endmodule

// File: rtl/phase_seq.sv
module phase_seq
  import phase_seq_pkg::*;
#(
  parameter int unsigned     PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ILEN-1:0]       mem_rdata_i,
  input  logic                  shift_stall_i,
  input  logic                  unalign_stall_i,
  input  logic                  branch_taken_i,
  input  logic [PC_W-1:0]       branch_target_i,
  output logic [1:0]            phase_o,
  output logic [PC_W-1:0]       pc_o,
  output logic                  mem_data_sel_o,
  output logic                  ir_en_o,
  output logic                  rf_we_o,
  output logic [ILEN-1:0]       instr_o,
  output logic [REG_AW-1:0]     rd_o,
  output logic [REG_AW-1:0]     rs1_o,
  output logic [REG_AW-1:0]     rs2_o,
  output logic [2:0]            funct3_o,
  output logic [ILEN-1:0]       imm_o,
  output logic                  shift_op_o,
  output logic                  shift_right_o,
  output logic                  shift_arith_o
);
  phase_e  phase;
  logic    stall, is_fetch, is_decode, is_exec, exec_last, wb_ok;
  fields_t fields;

  assign stall = shift_stall_i || unalign_stall_i;

  seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stall_i     (stall),
    .phase_o     (phase),
    .fetch_o     (is_fetch),
    .decode_o    (is_decode),
    .exec_o      (is_exec),
    .exec_last_o (exec_last)
  );

  seq_pc #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_pc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (is_fetch),
    .load_i   (exec_last && branch_taken_i),
    .target_i (branch_target_i),
    .pc_o     (pc_o)
  );

  seq_decode u_dec (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (is_decode),
    .word_i        (mem_rdata_i),
    .instr_o       (instr_o),
    .fields_o      (fields),
    .imm_o         (imm_o),
    .shift_op_o    (shift_op_o),
    .shift_right_o (shift_right_o),
    .shift_arith_o (shift_arith_o),
    .wb_ok_o       (wb_ok)
  );

  assign phase_o        = phase;
  assign mem_data_sel_o = is_exec;
  assign ir_en_o        = is_decode;
  assign rf_we_o        = exec_last && wb_ok;
  assign rd_o           = fields.rd;
  assign rs1_o          = fields.rs1;
  assign rs2_o          = fields.rs2;
  assign funct3_o       = fields.funct3;
endmodule

// File: rtl/phase_seq_chk.sv
module phase_seq_chk #(
  parameter int unsigned PC_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            shift_stall_i,
  input logic            unalign_stall_i,
  input logic            branch_taken_i,
  input logic [PC_W-1:0] branch_target_i,
  input logic [1:0]      phase_o,
  input logic [PC_W-1:0] pc_o,
  input logic            mem_data_sel_o,
  input logic            rf_we_o,
  input logic [31:0]     instr_o,
  input logic [31:0]     imm_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic stl;
  assign stl = shift_stall_i || unalign_stall_i;

  // R2
  fetch_to_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd0) |=> (phase_o == 2'd1));

  // R2
  decode_to_exec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd1) |=> (phase_o == 2'd2));

  // R2
  port_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != 2'd2) |-> !mem_data_sel_o);

  // R3
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd0) |=> (pc_o == $past(pc_o) + STEP));

  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd2 && stl) |=>
      (phase_o == 2'd2 && $stable(pc_o) && $stable(instr_o) && $stable(imm_o)));

  // R7
  exec_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd2 && !stl) |=> (phase_o == 2'd0));

  // R9
  branch_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd2 && !stl && branch_taken_i) |=> (pc_o == $past(branch_target_i)));

  // R9
  no_branch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd2 && !branch_taken_i) |=> $stable(pc_o));

  // R10
  we_final_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (phase_o == 2'd2 && !stl));

  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (phase_o == 2'd0 && !rf_we_o && !mem_data_sel_o));
endmodule

bind phase_seq phase_seq_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/phase_seq_test.sv
`timescale 1ns/100ps
module phase_seq_test;
  localparam int PC_W = 32;
  localparam logic [31:0] JUNK_TGT = 32'hDEAD_BEE0;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [31:0]     mem_rdata_i = '0;
  logic            shift_stall_i = 1'b0;
  logic            unalign_stall_i = 1'b0;
  logic            branch_taken_i = 1'b1;
  logic [PC_W-1:0] branch_target_i = JUNK_TGT;
  logic [1:0]      phase_o;
  logic [PC_W-1:0] pc_o;
  logic            mem_data_sel_o, ir_en_o, rf_we_o;
  logic [31:0]     instr_o, imm_o;
  logic [4:0]      rd_o, rs1_o, rs2_o;
  logic [2:0]      funct3_o;
  logic            shift_op_o, shift_right_o, shift_arith_o;

  phase_seq #(.PC_W(PC_W)) uut (.*);

  always #2.5 clk_i = ~clk_i;

  typedef struct {
    int          cycles;
    logic [31:0] next_pc;
    int          we_cnt;
    logic [31:0] word;
    logic [31:0] imm;
    logic [2:0]  sh;
  } item_t;

  item_t       exp_q[$];
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;
  logic [31:0] drv_pc = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called just after the negedge inside a fetch cycle
  task automatic run_instr(input logic [31:0] word, input int nsh, input int nun,
                           input bit taken, input logic [31:0] off,
                           input logic [31:0] imm, input bit we, input logic [2:0] sh);
    item_t it;
    int s;
    s = nsh + nun;
    it.cycles  = 3 + s;
    it.next_pc = taken ? drv_pc + off : drv_pc + 32'd4;
    it.we_cnt  = we ? 1 : 0;
    it.word    = word;
    it.imm     = imm;
    it.sh      = sh;
    exp_q.push_back(it);
    @(negedge clk_i);
    mem_rdata_i = word;                       // decode: memory answers
    @(negedge clk_i);
    mem_rdata_i = '0;
    for (int k = 0; k <= s; k++) begin
      shift_stall_i   = (k < nsh);
      unalign_stall_i = (k >= nsh) && (k < s);
      if (k == s) begin
        branch_taken_i  = taken;
        branch_target_i = drv_pc + off;
      end else begin
        branch_taken_i  = 1'b1;               // R9: must be ignored while stalled
        branch_target_i = JUNK_TGT;
      end
      @(negedge clk_i);
    end
    shift_stall_i   = 1'b0;
    unalign_stall_i = 1'b0;
    branch_taken_i  = 1'b1;                   // R9: ignored outside execute
    branch_target_i = JUNK_TGT;
    drv_pc = it.next_pc;
  endtask

  // monitor / scoreboard
  bit          inflight = 1'b0;
  int          cyc = 0;
  int          we_seen = 0;
  logic [31:0] fetch_pc = '0;
  logic [31:0] cap_instr, cap_imm;
  logic [4:0]  cap_rd, cap_rs1, cap_rs2;
  logic [2:0]  cap_f3, cap_sh;

  always begin
    @(negedge clk_i);
    #1;
    if (rst_ni && !done) begin
      case (phase_o)
        2'd0: begin
          if (inflight) begin
            if (exp_q.size() == 0) begin
              chk("R2 unexpected instruction", 32'd1, 32'd0);
            end else begin
              item_t e;
              e = exp_q.pop_front();
              chk("R7/R8 instruction length", 32'(cyc), 32'(e.cycles));
              chk("R3/R9 next pc", pc_o, e.next_pc);
              chk("R10 write pulses", 32'(we_seen), 32'(e.we_cnt));
              chk("R4 captured word", cap_instr, e.word);
              chk("R4 rd", 32'(cap_rd), 32'(e.word[11:7]));
              chk("R4 rs1", 32'(cap_rs1), 32'(e.word[19:15]));
              chk("R4 rs2", 32'(cap_rs2), 32'(e.word[24:20]));
              chk("R4 funct3", 32'(cap_f3), 32'(e.word[14:12]));
              chk("R5 immediate", cap_imm, e.imm);
              chk("R6 shift flags", 32'(cap_sh), 32'(e.sh));
            end
          end
          chk("R2 fetch addr select", 32'(mem_data_sel_o), 32'd0);
          inflight = 1'b1;
          cyc      = 1;
          we_seen  = 0;
          fetch_pc = pc_o;
        end
        2'd1: begin
          cyc++;
          chk("R3 pc in decode", pc_o, fetch_pc + 32'd4);
          chk("R2 decode addr select", 32'(mem_data_sel_o), 32'd0);
        end
        default: begin
          cyc++;
          chk("R2 exec addr select", 32'(mem_data_sel_o), 32'd1);
          if (rf_we_o) we_seen++;
          cap_instr = instr_o;
          cap_imm   = imm_o;
          cap_rd    = rd_o;
          cap_rs1   = rs1_o;
          cap_rs2   = rs2_o;
          cap_f3    = funct3_o;
          cap_sh    = {shift_op_o, shift_right_o, shift_arith_o};
        end
      endcase
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1 reset phase", 32'(phase_o), 32'd0);
    chk("R1 reset pc", pc_o, 32'd0);
    chk("R1 reset write enable", 32'(rf_we_o), 32'd0);
    chk("R1 reset addr select", 32'(mem_data_sel_o), 32'd0);
    @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 first fetch pc", pc_o, 32'd0);
    //          word          nsh nun tk off       imm           we sh
    run_instr(32'hFFD00293,  0,  0, 0, 32'd0,  32'hFFFF_FFFD, 1, 3'b000); // addi x5,x0,-3
    run_instr(32'h00528333,  0,  0, 0, 32'd0,  32'h0,         1, 3'b000); // add
    run_instr(32'h00429393,  4,  0, 0, 32'd0,  32'd4,         1, 3'b100); // R8 slli 4
    run_instr(32'h41F2D413, 31,  0, 0, 32'd0,  32'h41F,       1, 3'b111); // R8 srai 31
    run_instr(32'h006122A3,  0,  1, 0, 32'd0,  32'd5,         0, 3'b000); // R8 R10 sw unaligned
    run_instr(32'hFFC12483,  0,  0, 0, 32'd0,  32'hFFFF_FFFC, 1, 3'b000); // lw aligned
    run_instr(32'h00212503,  0,  1, 0, 32'd0,  32'd2,         1, 3'b000); // R8 lw unaligned
    run_instr(32'h00000863,  0,  0, 1, 32'd16, 32'd16,        0, 3'b000); // R9 beq taken
    run_instr(32'h00000013,  0,  0, 0, 32'd0,  32'd0,         0, 3'b000); // R10 rd=x0
    run_instr(32'hFE209CE3,  0,  0, 0, 32'd0,  32'hFFFF_FFF8, 0, 3'b000); // R9 bne not taken
    run_instr(32'h008000EF,  0,  0, 1, 32'd8,  32'd8,         1, 3'b000); // R9 jal
    run_instr(32'h123455B7,  0,  0, 0, 32'd0,  32'h1234_5000, 1, 3'b000); // R5 lui
    run_instr(32'h00629633,  2,  0, 0, 32'd0,  32'd0,         1, 3'b100); // R6 sll
    run_instr(32'h4062D6B3,  0,  0, 0, 32'd0,  32'd0,         1, 3'b111); // R6 sra by 0
    run_instr(32'h00000863,  3,  1, 1, 32'h40, 32'd16,        0, 3'b000); // R7 both stalls
    #2;
    chk("R2 scoreboard drained", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule